// File: doc/BRIEF.md
# Silent Store Detecting Load/Store Queue

This block is a circular load/store queue for an out-of-order core. Each entry carries a copy of its address and data, and that copy is allocated and freed in the same order as the queue entry itself. Because the copy lives beside its entry, it needs no tags and no replacement choice. When a store's address and data are both known, the block compares the store with the older entries still in the queue. The store is marked silent when it would write a value that the nearest older access to the same address has already shown is in memory. That older access can be a load that returned data (write after read) or an older store (write after write). Stores marked silent retire without issuing a write, so the cache sees no read-back traffic for this check.

Software ordering points are handled through a barrier input, which stops every value currently in the queue from being used as a reference. An external invalidation of an address removes the load values held for that address. Retirement is strictly in order from the head. The silent flag of the head store is settled before the head can retire.

The queue depth must be a power of two; the default is 32 entries.

Top module: `lsq_silent_top`

## Requirements
- R1: After reset the queue is empty: `q_full` is 0, `head_ready` is 0, `wr_valid` is 0 and `alloc_idx` is 0.
- R2: Allocation takes slots in circular order, and `alloc_idx` advances by one modulo the depth per accepted allocation. After depth allocations with no retirement, `q_full` is 1, and a further allocation is ignored: `alloc_idx` does not move and no extra entry is created.
- R3: A store whose nearest older resolved same-address entry is a load that returned the same data is flagged silent (write after read). A store with different data, or with no same-address older entry, is not silent.
- R4: A store whose nearest older resolved same-address entry is a store with equal data is flagged silent (write after write).
- R5: Only the nearest older resolved same-address entry decides. If it holds different data, the store is not silent, even when an entry further back matches.
- R6: An entry whose address or data is still unknown is never used as a reference. The search passes over it to older entries. A store's own verdict is taken once, in the cycle after both of its fields become known.
- R7: A barrier pulse stops every entry present at that moment from serving as a reference and clears the silent flag of every present store. Entries allocated in or after the barrier cycle act as references normally.
- R8: An invalidation of address A stops resolved loads at A from serving as references and clears the silent flag of resolved stores at A. Older stores at A remain valid references for stores that resolve later. Other addresses are unaffected.
- R9: `head_ready` is 1 only when the head entry is valid, both of its fields are known, and its verdict cycle has passed. `commit` while not ready is ignored. A ready commit of a non-silent store raises `wr_valid` for one cycle, on the following cycle, with that store's address and data. Loads and silent stores retire with no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate one entry at the tail |
| alloc_store | input | 1 | 1 = new entry is a store, 0 = load |
| alloc_idx | output | IW | Slot the next allocation takes |
| q_full | output | 1 | All slots in use |
| addr_valid | input | 1 | Address update strobe |
| addr_idx | input | IW | Entry receiving the address |
| addr_val | input | AW | Address value |
| data_valid | input | 1 | Data update strobe (load return or store data) |
| data_idx | input | IW | Entry receiving the data |
| data_val | input | DW | Data value |
| barrier | input | 1 | Memory barrier pulse |
| inv_valid | input | 1 | External invalidation strobe |
| inv_addr | input | AW | Invalidated address |
| commit | input | 1 | Retire the head entry |
| head_ready | output | 1 | Head entry may retire |
| head_store | output | 1 | Head entry is a store |
| head_silent | output | 1 | Head store is flagged silent |
| wr_valid | output | 1 | Write request for a retired non-silent store |
| wr_addr | output | AW | Write request address |
| wr_data | output | DW | Write request data |

## Verification
The bench targets queues where the nearest same-address entry disagrees with one further back. A design that takes any match rather than the nearest one would squash a store that must write. It resolves stores past entries with unknown fields and past loads whose data has not yet returned, using a data value of zero. A design that trusted stale fields would flag such stores silent and drop real writes. Barrier and invalidation cases check that flagged stores lose their flag and still write, while stores allocated later may still be squashed by surviving older stores. Fill-to-full with an extra allocation, and commits before the verdict cycle, catch count overflow and premature retirement.

// File: rtl/lsq_silent_pkg.sv
package lsq_silent_pkg;

    // Per-entry status bits of the queue
    typedef struct packed {
        logic valid;     // slot occupied
        logic is_store;  // 1 = store, 0 = load
        logic addr_ok;   // address known
        logic data_ok;   // data known (load returned / store data ready)
        logic src_ok;    // may serve as reference for younger stores
        logic pend;      // verdict to be taken this cycle
        logic silent;    // store flagged silent
    } ent_flags_t;

endpackage

// File: rtl/lsq_ring_ptrs.sv
module lsq_ring_ptrs #(
    parameter int DEPTH = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    output logic [$clog2(DEPTH)-1:0]   head,
    output logic [$clog2(DEPTH)-1:0]   tail,
    output logic                       full,
    output logic                       empty
);
    localparam int IW = $clog2(DEPTH);

    typedef struct packed {
        logic [IW-1:0] head;
        logic [IW-1:0] tail;
        logic [IW:0]   count;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (push) begin
            ptr_d.tail = ptr_q.tail + 1'b1;
        end
        if (pop) begin
            ptr_d.head = ptr_q.head + 1'b1;
        end
        case ({push, pop})
            2'b10:   ptr_d.count = ptr_q.count + 1'b1;
            2'b01:   ptr_d.count = ptr_q.count - 1'b1;
            default: ptr_d.count = ptr_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign head  = ptr_q.head;
    assign tail  = ptr_q.tail;
    assign full  = (ptr_q.count == (IW+1)'(DEPTH));
    assign empty = (ptr_q.count == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R9
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full); // R2

endmodule

// File: rtl/lsq_nearest_src.sv
module lsq_nearest_src #(
    parameter int DEPTH = 32,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int SELF  = 0
) (
    input  logic [$clog2(DEPTH)-1:0]   head,
    input  logic [DEPTH-1:0]           cand,
    input  logic [DEPTH-1:0][AW-1:0]   addrs,
    input  logic [DEPTH-1:0][DW-1:0]   datas,
    output logic                       silent_hit
);
    localparam int IW = $clog2(DEPTH);
    localparam logic [IW-1:0] SELF_IDX = IW'(SELF);

    logic [IW-1:0] age_self;
    logic [IW-1:0] slot;
    logic          found;
    logic          same;

    // Walk from oldest to youngest; the last hit older than self is the nearest.
    always_comb begin
        age_self = SELF_IDX - head;
        found    = 1'b0;
        same     = 1'b0;
        slot     = '0;
        for (int k = 0; k < DEPTH; k++) begin
            slot = head + k[IW-1:0];
            if ((k[IW-1:0] < age_self) && cand[slot] &&
                (addrs[slot] == addrs[SELF_IDX])) begin
                found = 1'b1;
                same  = (datas[slot] == datas[SELF_IDX]);
            end
        end
        silent_hit = found && same;
    end

endmodule

// File: rtl/lsq_silent_top.sv
module lsq_silent_top #(
    parameter int DEPTH = 32,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic          alloc_store,
    output logic [IW-1:0] alloc_idx,
    output logic          q_full,
    input  logic          addr_valid,
    input  logic [IW-1:0] addr_idx,
    input  logic [AW-1:0] addr_val,
    input  logic          data_valid,
    input  logic [IW-1:0] data_idx,
    input  logic [DW-1:0] data_val,
    input  logic          barrier,
    input  logic          inv_valid,
    input  logic [AW-1:0] inv_addr,
    input  logic          commit,
    output logic          head_ready,
    output logic          head_store,
    output logic          head_silent,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    import lsq_silent_pkg::*;

    typedef struct packed {
        ent_flags_t [DEPTH-1:0]         fl;
        logic       [DEPTH-1:0][AW-1:0] addr;
        logic       [DEPTH-1:0][DW-1:0] data;
        logic                           wr_v;
        logic       [AW-1:0]            wr_a;
        logic       [DW-1:0]            wr_d;
    } lsq_state_t;

    lsq_state_t st_d, st_q;

    logic [IW-1:0]    head_w, tail_w;
    logic             full_w, empty_w;
    logic             alloc_ok, commit_ok;
    logic [DEPTH-1:0] cand;
    logic [DEPTH-1:0] hit;

    assign alloc_ok   = alloc_valid && !full_w;
    assign head_ready = st_q.fl[head_w].valid && st_q.fl[head_w].addr_ok &&
                        st_q.fl[head_w].data_ok && !st_q.fl[head_w].pend;
    assign commit_ok  = commit && head_ready;

    lsq_ring_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (alloc_ok),
        .pop   (commit_ok),
        .head  (head_w),
        .tail  (tail_w),
        .full  (full_w),
        .empty (empty_w)
    );

    // One nearest-older search per slot
    genvar e;
    generate
        for (e = 0; e < DEPTH; e++) begin : g_src
            assign cand[e] = st_q.fl[e].valid && st_q.fl[e].addr_ok &&
                             st_q.fl[e].data_ok && st_q.fl[e].src_ok;
            lsq_nearest_src #(
                .DEPTH (DEPTH),
                .AW    (AW),
                .DW    (DW),
                .SELF  (e)
            ) u_src (
                .head       (head_w),
                .cand       (cand),
                .addrs      (st_q.addr),
                .datas      (st_q.data),
                .silent_hit (hit[e])
            );
        end
    endgenerate

    always_comb begin
        st_d      = st_q;
        st_d.wr_v = 1'b0;

        // field updates: only first write of a field to a live entry counts
        if (addr_valid && st_q.fl[addr_idx].valid && !st_q.fl[addr_idx].addr_ok) begin
            st_d.addr[addr_idx]       = addr_val;
            st_d.fl[addr_idx].addr_ok = 1'b1;
        end
        if (data_valid && st_q.fl[data_idx].valid && !st_q.fl[data_idx].data_ok) begin
            st_d.data[data_idx]       = data_val;
            st_d.fl[data_idx].data_ok = 1'b1;
        end

        for (int i = 0; i < DEPTH; i++) begin
            // verdict taken one cycle after resolution
            if (st_q.fl[i].pend) begin
                st_d.fl[i].pend   = 1'b0;
                st_d.fl[i].silent = st_q.fl[i].is_store && hit[i];
            end
            // newly resolved entries schedule their verdict
            if (st_d.fl[i].valid && st_d.fl[i].addr_ok && st_d.fl[i].data_ok &&
                !(st_q.fl[i].addr_ok && st_q.fl[i].data_ok)) begin
                st_d.fl[i].pend = 1'b1;
            end
            // external invalidation
            if (inv_valid && st_q.fl[i].valid && st_q.fl[i].addr_ok &&
                st_q.fl[i].data_ok && (st_q.addr[i] == inv_addr)) begin
                if (st_q.fl[i].is_store) begin
                    st_d.fl[i].silent = 1'b0;
                end else begin
                    st_d.fl[i].src_ok = 1'b0;
                end
            end
            // barrier flushes every saved value
            if (barrier) begin
                st_d.fl[i].src_ok = 1'b0;
                st_d.fl[i].silent = 1'b0;
            end
        end

        if (commit_ok) begin
            if (st_q.fl[head_w].is_store && !st_q.fl[head_w].silent) begin
                st_d.wr_v = 1'b1;
                st_d.wr_a = st_q.addr[head_w];
                st_d.wr_d = st_q.data[head_w];
            end
            st_d.fl[head_w] = '0;
        end

        if (alloc_ok) begin
            st_d.fl[tail_w]          = '0;
            st_d.fl[tail_w].valid    = 1'b1;
            st_d.fl[tail_w].is_store = alloc_store;
            st_d.fl[tail_w].src_ok   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alloc_idx   = tail_w;
    assign q_full      = full_w;
    assign head_store  = st_q.fl[head_w].valid && st_q.fl[head_w].is_store;
    assign head_silent = head_store && st_q.fl[head_w].silent;
    assign wr_valid    = st_q.wr_v;
    assign wr_addr     = st_q.wr_a;
    assign wr_data     = st_q.wr_d;

    AST_WR_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> $past(commit)); // R9
    AST_SILENT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && head_ready && head_silent) |=> !wr_valid); // R9
    AST_STORE_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && head_ready && head_store && !head_silent) |=> wr_valid); // R9
    AST_BARRIER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        barrier |=> !head_silent); // R7
    AST_READY_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        head_ready |-> !empty_w); // R9

endmodule

// File: tb/lsq_silent_top_bench.sv
module lsq_silent_top_bench;
    localparam int DEPTH = 32;
    localparam int AW    = 16;
    localparam int DW    = 32;
    localparam int IW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_valid = 1'b0, alloc_store = 1'b0;
    logic [IW-1:0] alloc_idx;
    logic          q_full;
    logic          addr_valid = 1'b0;
    logic [IW-1:0] addr_idx = '0;
    logic [AW-1:0] addr_val = '0;
    logic          data_valid = 1'b0;
    logic [IW-1:0] data_idx = '0;
    logic [DW-1:0] data_val = '0;
    logic          barrier = 1'b0, inv_valid = 1'b0;
    logic [AW-1:0] inv_addr = '0;
    logic          commit = 1'b0;
    logic          head_ready, head_store, head_silent, wr_valid;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int  total = 0, bad = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    lsq_silent_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_lsq_silent_top (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_store(alloc_store), .alloc_idx(alloc_idx),
        .q_full(q_full),
        .addr_valid(addr_valid), .addr_idx(addr_idx), .addr_val(addr_val),
        .data_valid(data_valid), .data_idx(data_idx), .data_val(data_val),
        .barrier(barrier), .inv_valid(inv_valid), .inv_addr(inv_addr),
        .commit(commit), .head_ready(head_ready), .head_store(head_store),
        .head_silent(head_silent),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_alloc(input bit st, output logic [IW-1:0] idx);
        idx         = alloc_idx;
        alloc_valid = 1'b1;
        alloc_store = st;
        @(negedge clk);
        alloc_valid = 1'b0;
    endtask

    task automatic set_a(input logic [IW-1:0] idx, input logic [AW-1:0] a);
        addr_valid = 1'b1; addr_idx = idx; addr_val = a;
        @(negedge clk);
        addr_valid = 1'b0;
    endtask

    task automatic set_d(input logic [IW-1:0] idx, input logic [DW-1:0] d);
        data_valid = 1'b1; data_idx = idx; data_val = d;
        @(negedge clk);
        data_valid = 1'b0;
    endtask

    task automatic set_ad(input logic [IW-1:0] idx, input logic [AW-1:0] a,
                          input logic [DW-1:0] d);
        addr_valid = 1'b1; addr_idx = idx; addr_val = a;
        data_valid = 1'b1; data_idx = idx; data_val = d;
        @(negedge clk);
        addr_valid = 1'b0; data_valid = 1'b0;
    endtask

    // Allocate and fully resolve one entry
    task automatic push_entry(input bit st, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, output logic [IW-1:0] idx);
        do_alloc(st, idx);
        set_ad(idx, a, d);
    endtask

    task automatic expect_commit(input bit st, input bit sil, input logic [AW-1:0] a,
                                 input logic [DW-1:0] d, input string req);
        bit exp_w;
        chk(head_ready == 1'b1, req, "head_ready", head_ready, 1);
        chk(head_store == st, req, "head_store", head_store, st);
        if (st) chk(head_silent == sil, req, "head_silent", head_silent, sil);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        exp_w = st && !sil;
        chk(wr_valid == exp_w, req, "wr_valid", wr_valid, exp_w);
        if (exp_w) begin
            chk(wr_addr == a, req, "wr_addr", wr_addr, a);
            chk(wr_data == d, req, "wr_data", wr_data, d);
        end
    endtask

    task automatic t_reset;
        chk(q_full == 1'b0, "R1", "q_full", q_full, 0);
        chk(head_ready == 1'b0, "R1", "head_ready", head_ready, 0);
        chk(wr_valid == 1'b0, "R1", "wr_valid", wr_valid, 0);
        chk(alloc_idx == '0, "R1", "alloc_idx", alloc_idx, 0);
    endtask

    task automatic t_commit_gate;
        logic [IW-1:0] s;
        do_alloc(1'b1, s);
        set_a(s, 16'h0700);
        idle(2);
        chk(head_ready == 1'b0, "R9", "ready with unknown data", head_ready, 0);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
        chk(wr_valid == 1'b0, "R9", "ignored commit write", wr_valid, 0);
        chk(head_ready == 1'b0, "R9", "entry kept", head_ready, 0);
        set_d(s, 32'h1234_5678);
        chk(head_ready == 1'b0, "R9", "ready during verdict cycle", head_ready, 0);
        @(negedge clk);
        expect_commit(1'b1, 1'b0, 16'h0700, 32'h1234_5678, "R9");
    endtask

    task automatic t_war;
        logic [IW-1:0] x;
        push_entry(1'b0, 16'h0010, 32'hAA, x);
        push_entry(1'b1, 16'h0010, 32'hAA, x);
        push_entry(1'b1, 16'h0010, 32'hAB, x);
        push_entry(1'b1, 16'h0014, 32'hAA, x);
        idle(2);
        expect_commit(1'b0, 1'b0, '0, '0, "R3");
        expect_commit(1'b1, 1'b1, '0, '0, "R3");
        expect_commit(1'b1, 1'b0, 16'h0010, 32'hAB, "R3");
        expect_commit(1'b1, 1'b0, 16'h0014, 32'hAA, "R3");
    endtask

    task automatic t_waw;
        logic [IW-1:0] x;
        push_entry(1'b1, 16'h0020, 32'h5, x);
        push_entry(1'b1, 16'h0020, 32'h5, x);
        idle(2);
        expect_commit(1'b1, 1'b0, 16'h0020, 32'h5, "R4");
        expect_commit(1'b1, 1'b1, '0, '0, "R4");
    endtask

    task automatic t_nearest;
        logic [IW-1:0] x;
        push_entry(1'b0, 16'h0030, 32'h7, x);
        push_entry(1'b1, 16'h0030, 32'h9, x);
        push_entry(1'b1, 16'h0030, 32'h7, x);
        idle(2);
        expect_commit(1'b0, 1'b0, '0, '0, "R5");
        expect_commit(1'b1, 1'b0, 16'h0030, 32'h9, "R5");
        expect_commit(1'b1, 1'b0, 16'h0030, 32'h7, "R5");
    endtask

    task automatic t_unresolved;
        logic [IW-1:0] x, sx, l2;
        push_entry(1'b0, 16'h0040, 32'h3, x);
        do_alloc(1'b1, sx);
        set_a(sx, 16'h0040);
        push_entry(1'b1, 16'h0040, 32'h3, x);
        do_alloc(1'b0, l2);
        set_a(l2, 16'h0044);
        push_entry(1'b1, 16'h0044, 32'h0, x);
        idle(2);
        set_d(l2, 32'h0);
        set_d(sx, 32'h8);
        idle(2);
        expect_commit(1'b0, 1'b0, '0, '0, "R6");
        expect_commit(1'b1, 1'b0, 16'h0040, 32'h8, "R6");
        expect_commit(1'b1, 1'b1, '0, '0, "R6");
        expect_commit(1'b0, 1'b0, '0, '0, "R6");
        expect_commit(1'b1, 1'b0, 16'h0044, 32'h0, "R6");
    endtask

    task automatic t_barrier;
        logic [IW-1:0] x;
        push_entry(1'b0, 16'h0050, 32'h1, x);
        push_entry(1'b1, 16'h0050, 32'h1, x);
        idle(2);
        barrier = 1'b1;
        @(negedge clk);
        barrier = 1'b0;
        push_entry(1'b1, 16'h0050, 32'h1, x);
        push_entry(1'b1, 16'h0050, 32'h1, x);
        idle(2);
        expect_commit(1'b0, 1'b0, '0, '0, "R7");
        expect_commit(1'b1, 1'b0, 16'h0050, 32'h1, "R7");
        expect_commit(1'b1, 1'b0, 16'h0050, 32'h1, "R7");
        expect_commit(1'b1, 1'b1, '0, '0, "R7");
    endtask

    task automatic pulse_inv(input logic [AW-1:0] a);
        inv_valid = 1'b1; inv_addr = a;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic t_inval;
        logic [IW-1:0] x;
        push_entry(1'b0, 16'h0060, 32'h2, x);
        push_entry(1'b1, 16'h0060, 32'h2, x);
        idle(2);
        pulse_inv(16'h0060);
        push_entry(1'b1, 16'h0060, 32'h2, x);
        push_entry(1'b0, 16'h0064, 32'h4, x);
        idle(2);
        pulse_inv(16'h0064);
        push_entry(1'b1, 16'h0064, 32'h4, x);
        push_entry(1'b0, 16'h0068, 32'h1, x);
        push_entry(1'b1, 16'h0068, 32'h1, x);
        idle(2);
        pulse_inv(16'h006C);
        idle(1);
        expect_commit(1'b0, 1'b0, '0, '0, "R8");
        expect_commit(1'b1, 1'b0, 16'h0060, 32'h2, "R8");
        expect_commit(1'b1, 1'b1, '0, '0, "R8");
        expect_commit(1'b0, 1'b0, '0, '0, "R8");
        expect_commit(1'b1, 1'b0, 16'h0064, 32'h4, "R8");
        expect_commit(1'b0, 1'b0, '0, '0, "R8");
        expect_commit(1'b1, 1'b1, '0, '0, "R8");
    endtask

    task automatic t_full;
        logic [IW-1:0] first, x;
        logic [IW-1:0] slots [DEPTH];
        first = alloc_idx;
        for (int k = 0; k < DEPTH; k++) begin
            chk(alloc_idx == IW'(first + k), "R2", "alloc order", alloc_idx, IW'(first + k));
            do_alloc(1'b0, slots[k]);
        end
        chk(q_full == 1'b1, "R2", "q_full after depth", q_full, 1);
        do_alloc(1'b1, x);
        chk(q_full == 1'b1, "R2", "full after extra", q_full, 1);
        chk(alloc_idx == first, "R2", "alloc_idx frozen", alloc_idx, first);
        for (int k = 0; k < DEPTH; k++) begin
            set_ad(slots[k], AW'(16'h0100 + k * 4), DW'(k));
        end
        idle(2);
        for (int k = 0; k < DEPTH; k++) begin
            expect_commit(1'b0, 1'b0, '0, '0, "R2");
        end
        chk(q_full == 1'b0, "R2", "q_full after drain", q_full, 0);
        chk(head_ready == 1'b0, "R2", "no extra entry", head_ready, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_commit_gate();
        t_war();
        t_waw();
        t_nearest();
        t_unresolved();
        t_barrier();
        t_inval();
        t_full();
        idle(2);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule